// File: doc/BRIEF.md
# GPIO Expander Register Bank

This block is the register core of a pin-expander that sits behind a serial host link. It owns up to 24 general-purpose pins, grouped into 8-bit ports, and keeps four register groups for them: a read-only view of the pad levels, the output levels to drive, a per-bit read inversion, and a per-bit direction selector. A byte-level transaction front end (the bit-level serial slave is outside this block) delivers transaction start and stop strobes, a direction flag, written bytes and read requests.

A write transaction sends a pointer byte first and then any number of data bytes. A read is done by a pointer-only write transaction, then a read transaction that pulls as many bytes as the host wants. The pointer advances after every data byte and wraps inside its register group, so a burst walks all ports of one group. The pointer keeps its value across transactions. There is no back-pressure: the core takes a strobe on every cycle, and read data always returns exactly one cycle after its request.

Top module: `gpx_bank`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero), every output register bit is 1 (`pin_out` all ones), and every inversion register bit is 0.
- R2: The pointer byte decodes as bits [7:4] (must be zero), bits [3:2] as the group (0 pad view, 1 output, 2 inversion, 3 direction) and bits [1:0] as the port. Pin n is bit n mod 8 of port n/8.
- R3: In a write transaction (`txn_is_read` low when `txn_start` pulses), the first `wr_stb` loads `wr_byte` into the pointer and changes no register.
- R4: Each later `wr_stb` in that write transaction stores `wr_byte` in the register the pointer names. Each `rd_stb` in a read transaction returns that register on `rd_byte`, with `rd_valid` high, one cycle later.
- R5: After every data byte at a defined address, the port field increments. It wraps from the last port to port 0 within the same group. The pointer keeps its value across stop and start.
- R6: A direction bit of 1 makes the pin an input (`pin_oe` low). A 0 makes it drive (`pin_oe` high). `pin_out` always follows the output register, so a level can be preset before the pin starts driving.
- R7: Reading the pad-view group returns the pad level after a SYNC_STAGES-flop synchronizer, XOR the inversion register. This holds whatever the pin direction. Writes to the pad-view group change nothing, but the pointer still advances.
- R8: An address with nonzero bits [7:4], or with a port field at or beyond the port count, reads as 0 and ignores writes. A data byte at such an address leaves the pointer unchanged.
- R9: In a read transaction, `wr_stb` is ignored and the pointer is never reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Transaction start strobe |
| txn_stop | input | 1 | Transaction stop strobe |
| txn_is_read | input | 1 | Direction of the starting transaction, 1 = read |
| wr_stb | input | 1 | Written-byte strobe |
| wr_byte | input | 8 | Written byte |
| rd_stb | input | 1 | Read-byte request |
| rd_byte | output | 8 | Returned byte, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after an accepted read request |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Level to drive per pin |
| pin_oe | output | NUM_PINS | Output enable per pin |

## Verification
The bench builds the core with NUM_PINS = 16, so two ports exist. Port fields 2 and 3 are then undefined, and the out-of-range decode can be seen next to a two-port wrap. With that size, every one of the 256 pointer values is read back against an arithmetic model. All 256 inversion patterns are also swept over pad patterns, and multi-byte bursts exercise the wrap in each writable group.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

  typedef enum logic [1:0] {
    GRP_PAD = 2'd0,
    GRP_OUT = 2'd1,
    GRP_INV = 2'd2,
    GRP_DIR = 2'd3
  } grp_e;

  typedef struct packed {
    logic [3:0] hi;
    grp_e       grp;
    logic [1:0] port;
  } ptr_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/gpx_ptr_ctrl.sv
module gpx_ptr_ctrl
  import gpx_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_start,
  input  logic       txn_stop,
  input  logic       txn_is_read,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       rd_stb,
  output ptr_t       ptr,
  output logic       ptr_ok,
  output logic       data_wr,
  output logic       data_rd
);

  localparam logic [1:0] LAST_PORT = 2'(NUM_PORTS - 1);

  logic in_txn;
  logic txn_rd;
  logic need_ptr;
  logic quiet;
  logic load;
  logic advance;
  ptr_t ptr_nxt;

  assign quiet   = ~txn_start & ~txn_stop;
  assign ptr_ok  = (ptr.hi == 4'd0) && (ptr.port <= LAST_PORT);
  assign load    = quiet & in_txn & ~txn_rd & need_ptr & wr_stb;
  assign data_wr = quiet & in_txn & ~txn_rd & ~need_ptr & wr_stb;
  assign data_rd = quiet & in_txn & txn_rd & rd_stb;
  assign advance = (data_wr | data_rd) & ptr_ok;

  always_comb begin
    ptr_nxt = ptr;
    if (load) begin
      ptr_nxt = ptr_t'(wr_byte);
    end else if (advance) begin
      ptr_nxt.port = (ptr.port == LAST_PORT) ? 2'd0 : ptr.port + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_txn   <= 1'b0;
      txn_rd   <= 1'b0;
      need_ptr <= 1'b0;
      ptr      <= '0;
    end else begin
      ptr <= ptr_nxt;
      if (txn_start) begin
        in_txn   <= 1'b1;
        txn_rd   <= txn_is_read;
        need_ptr <= ~txn_is_read;
      end else if (txn_stop) begin
        in_txn   <= 1'b0;
        need_ptr <= 1'b0;
      end else if (load) begin
        need_ptr <= 1'b0;
      end
    end
  end

  // R3: first byte of a write transaction becomes the pointer
  p_ptr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ptr == ptr_t'($past(wr_byte))));

  // R5: last port wraps to port 0 and keeps the group
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ptr.port == LAST_PORT) |=> (ptr.port == 2'd0 && $stable(ptr.grp)));

  // R8: a data byte at an undefined address does not move the pointer
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || data_rd) && !ptr_ok) |=> $stable(ptr));

  // R9: no pointer reload inside a read transaction
  p_no_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_txn && txn_rd && !txn_start && !advance) |=> $stable(ptr));

endmodule

// File: rtl/gpx_port_slice.sv
module gpx_port_slice #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] pad,
  input  logic [7:0] wdata,
  input  logic       wr_out,
  input  logic       wr_inv,
  input  logic       wr_dir,
  output logic [7:0] out_q,
  output logic [7:0] inv_q,
  output logic [7:0] dir_q,
  output logic [7:0] pad_view
);

  logic [7:0] sync_q [SYNC_STAGES];

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 8'h00;
          else        sync_q[s] <= pad;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 8'h00;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 8'hFF;
      inv_q <= 8'h00;
      dir_q <= 8'hFF;
    end else begin
      if (wr_out) out_q <= wdata;
      if (wr_inv) inv_q <= wdata;
      if (wr_dir) dir_q <= wdata;
    end
  end

  assign pad_view = sync_q[SYNC_STAGES-1] ^ inv_q;

  // R4: registers only change on their own write enable
  p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_out && !wr_inv && !wr_dir) |=> ($stable(out_q) && $stable(inv_q) && $stable(dir_q)));

endmodule

// File: rtl/gpx_read_mux.sv
module gpx_read_mux
  import gpx_pkg::*;
#(
  parameter int NUM_PORTS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  ptr_t                   ptr,
  input  logic                   ptr_ok,
  input  logic                   data_rd,
  input  logic [NUM_PORTS*8-1:0] pad_all,
  input  logic [NUM_PORTS*8-1:0] out_all,
  input  logic [NUM_PORTS*8-1:0] inv_all,
  input  logic [NUM_PORTS*8-1:0] dir_all,
  output logic [7:0]             rd_byte,
  output logic                   rd_valid
);

  logic [7:0] sel;
  int         base;

  always_comb begin
    base = int'(ptr.port) * 8;
    sel  = 8'h00;
    if (ptr_ok) begin
      unique case (ptr.grp)
        GRP_PAD: sel = pad_all[base +: 8];
        GRP_OUT: sel = out_all[base +: 8];
        GRP_INV: sel = inv_all[base +: 8];
        GRP_DIR: sel = dir_all[base +: 8];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_byte  <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= data_rd;
      if (data_rd) rd_byte <= sel;
    end
  end

  // R4: each accepted read request is answered the next cycle
  p_rd_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> rd_valid);

  // R8: undefined addresses return zero
  p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !ptr_ok) |=> (rd_byte == 8'h00));

endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
  import gpx_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txn_start,
  input  logic                txn_stop,
  input  logic                txn_is_read,
  input  logic                wr_stb,
  input  logic [7:0]          wr_byte,
  input  logic                rd_stb,
  output logic [7:0]          rd_byte,
  output logic                rd_valid,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam int NUM_PORTS = (NUM_PINS + 7) / 8;
  localparam int BANK_W    = NUM_PORTS * 8;

  ptr_t              ptr;
  logic              ptr_ok;
  logic              data_wr;
  logic              data_rd;
  logic [BANK_W-1:0] pad_all;
  logic [BANK_W-1:0] view_all;
  logic [BANK_W-1:0] out_all;
  logic [BANK_W-1:0] inv_all;
  logic [BANK_W-1:0] dir_all;

  always_comb begin
    pad_all               = '0;
    pad_all[NUM_PINS-1:0] = pin_in;
  end

  gpx_ptr_ctrl #(.NUM_PORTS(NUM_PORTS)) i_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_start  (txn_start),
    .txn_stop   (txn_stop),
    .txn_is_read(txn_is_read),
    .wr_stb     (wr_stb),
    .wr_byte    (wr_byte),
    .rd_stb     (rd_stb),
    .ptr        (ptr),
    .ptr_ok     (ptr_ok),
    .data_wr    (data_wr),
    .data_rd    (data_rd)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit;
      assign hit = data_wr && ptr_ok && (ptr.port == 2'(p));
      gpx_port_slice #(.SYNC_STAGES(SYNC_STAGES)) i_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad     (pad_all[p*8 +: 8]),
        .wdata   (wr_byte),
        .wr_out  (hit && ptr.grp == GRP_OUT),
        .wr_inv  (hit && ptr.grp == GRP_INV),
        .wr_dir  (hit && ptr.grp == GRP_DIR),
        .out_q   (out_all[p*8 +: 8]),
        .inv_q   (inv_all[p*8 +: 8]),
        .dir_q   (dir_all[p*8 +: 8]),
        .pad_view(view_all[p*8 +: 8])
      );
    end
  endgenerate

  gpx_read_mux #(.NUM_PORTS(NUM_PORTS)) i_rmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .ptr     (ptr),
    .ptr_ok  (ptr_ok),
    .data_rd (data_rd),
    .pad_all (view_all),
    .out_all (out_all),
    .inv_all (inv_all),
    .dir_all (dir_all),
    .rd_byte (rd_byte),
    .rd_valid(rd_valid)
  );

  assign pin_out = out_all[NUM_PINS-1:0];
  assign pin_oe  = ~dir_all[NUM_PINS-1:0];

  // R7: a write aimed at the pad-view group leaves the pins untouched
  p_pad_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr.grp == GRP_PAD) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R8: a write to an undefined address leaves the pins untouched
  p_undef_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ptr_ok) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R9: bytes written inside a read transaction never reach the pins
  p_rd_txn_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

// File: tb/test_gpx_bank.sv
`timescale 1ns/1ps
module test_gpx_bank;

  localparam int NP    = 16;
  localparam int PORTS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          txn_start = 1'b0, txn_stop = 1'b0, txn_is_read = 1'b0;
  logic          wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]    wr_byte = 8'h00;
  logic [7:0]    rd_byte;
  logic          rd_valid;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] m_out [PORTS];
  logic [7:0] m_inv [PORTS];
  logic [7:0] m_dir [PORTS];
  logic [7:0] m_ptr;

  always #2.5 clk = ~clk;

  gpx_bank #(.NUM_PINS(NP), .SYNC_STAGES(2)) i_gpx_bank (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_stop(txn_stop),
    .txn_is_read(txn_is_read), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .rd_stb(rd_stb), .rd_byte(rd_byte), .rd_valid(rd_valid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit addr_ok(input logic [7:0] a);
    return (a[7:4] == 4'd0) && (int'(a[1:0]) < PORTS);
  endfunction

  function automatic logic [7:0] next_ptr(input logic [7:0] a);
    if (!addr_ok(a)) return a;
    return {a[7:2], (int'(a[1:0]) == PORTS-1) ? 2'd0 : a[1:0] + 2'd1};
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    int p;
    if (!addr_ok(a)) return 8'h00;
    p = int'(a[1:0]);
    case (a[3:2])
      2'd0:    return pin_in[p*8 +: 8] ^ m_inv[p];
      2'd1:    return m_out[p];
      2'd2:    return m_inv[p];
      default: return m_dir[p];
    endcase
  endfunction

  task automatic tick; @(negedge clk); endtask

  task automatic open_txn(input bit rd);
    txn_start = 1'b1; txn_is_read = rd; tick; txn_start = 1'b0;
  endtask

  task automatic close_txn;
    txn_stop = 1'b1; tick; txn_stop = 1'b0;
  endtask

  task automatic put(input logic [7:0] b);
    wr_stb = 1'b1; wr_byte = b; tick; wr_stb = 1'b0;
  endtask

  task automatic get(output logic [7:0] b, output logic v);
    rd_stb = 1'b1; tick; rd_stb = 1'b0; b = rd_byte; v = rd_valid;
  endtask

  // Write transaction: pointer then n data bytes, model updated alongside
  task automatic wr_txn(input logic [7:0] a, input logic [7:0] d0,
                        input logic [7:0] d1, input logic [7:0] d2, input int n);
    logic [7:0] d;
    int p;
    open_txn(1'b0);
    put(a);
    m_ptr = a;
    for (int i = 0; i < n; i++) begin
      d = (i == 0) ? d0 : (i == 1) ? d1 : d2;
      put(d);
      if (addr_ok(m_ptr)) begin
        p = int'(m_ptr[1:0]);
        case (m_ptr[3:2])
          2'd1: m_out[p] = d;
          2'd2: m_inv[p] = d;
          2'd3: m_dir[p] = d;
          default: ;
        endcase
      end
      m_ptr = next_ptr(m_ptr);
    end
    close_txn;
  endtask

  // Read transaction of n bytes from the current pointer, checked against the model
  task automatic rd_txn(input int n, input string tag);
    logic [7:0] b;
    logic v;
    open_txn(1'b1);
    for (int i = 0; i < n; i++) begin
      get(b, v);
      chk({24'd0, b}, {24'd0, exp_rd(m_ptr)}, tag);
      chk({31'd0, v}, 32'd1, {tag, " R4 rd_valid"});
      m_ptr = next_ptr(m_ptr);
    end
    close_txn;
  endtask

  task automatic settle; repeat (4) tick; endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int p = 0; p < PORTS; p++) begin
      m_out[p] = 8'hFF; m_inv[p] = 8'h00; m_dir[p] = 8'hFF;
    end
    m_ptr = 8'h00;
    repeat (3) tick;
    rst_n = 1'b1;
    tick;

    // R1: reset state at the pins and in the inversion registers
    chk({16'd0, pin_oe}, 32'h0, "R1 pin_oe");
    chk({16'd0, pin_out}, 32'hFFFF, "R1 pin_out");
    wr_txn(8'h08, 8'h00, 8'h00, 8'h00, 0);
    rd_txn(2, "R1 inversion");

    // R2 R8: sweep every pointer value with a fixed pad pattern
    pin_in = 16'hA53C;
    settle;
    for (int a = 0; a < 256; a++) begin
      wr_txn(8'(a), 8'h00, 8'h00, 8'h00, 0);
      rd_txn(1, "R2 R8 address sweep");
    end

    // R6: direction and preset output per port
    wr_txn(8'h04, 8'h5A, 8'hC3, 8'h00, 2);
    chk({16'd0, pin_out}, 32'hC35A, "R6 preset output");
    chk({16'd0, pin_oe}, 32'h0, "R6 still inputs");
    wr_txn(8'h0C, 8'h0F, 8'hF0, 8'h00, 2);
    chk({16'd0, pin_oe}, 32'h0FF0, "R6 direction");
    chk({16'd0, pin_out}, 32'hC35A, "R6 output kept");

    // R5: burst wraps inside the group, pointer kept across stop/start
    wr_txn(8'h05, 8'h11, 8'h22, 8'h33, 3);
    chk({16'd0, pin_out}, 32'h3322, "R5 wrap output");
    rd_txn(3, "R5 continued pointer");
    wr_txn(8'h0D, 8'h00, 8'h00, 8'h00, 0);
    rd_txn(3, "R5 read wrap dir");

    // R7: pad view with outputs driving, writes to pad group ignored
    pin_in = 16'h1E87;
    settle;
    wr_txn(8'h00, 8'hFF, 8'hFF, 8'h00, 2);
    chk({16'd0, pin_out}, 32'h3322, "R7 pad write ignored out");
    chk({16'd0, pin_oe}, 32'h0FF0, "R7 pad write ignored oe");
    wr_txn(8'h00, 8'h00, 8'h00, 8'h00, 0);
    rd_txn(2, "R7 pad level any direction");

    // R7: all inversion patterns against several pad patterns
    for (int pat = 0; pat < 4; pat++) begin
      pin_in = (pat == 0) ? 16'h0000 : (pat == 1) ? 16'hFFFF :
               (pat == 2) ? 16'h6C93 : 16'h0F5A;
      settle;
      for (int inv = 0; inv < 256; inv++) begin
        wr_txn(8'h08, 8'(inv), 8'(255 - inv), 8'h00, 2);
        wr_txn(8'h00, 8'h00, 8'h00, 8'h00, 0);
        rd_txn(2, "R7 inversion sweep");
      end
    end

    // R8: writes to undefined addresses ignored, pointer held
    wr_txn(8'h06, 8'h00, 8'h00, 8'h00, 2);
    wr_txn(8'h25, 8'h00, 8'h00, 8'h00, 1);
    chk({16'd0, pin_out}, 32'h3322, "R8 undefined write out");
    chk({16'd0, pin_oe}, 32'h0FF0, "R8 undefined write oe");
    wr_txn(8'h07, 8'h00, 8'h00, 8'h00, 0);
    rd_txn(3, "R8 held pointer reads zero");

    // R9: write strobes inside a read transaction are ignored
    wr_txn(8'h04, 8'h00, 8'h00, 8'h00, 0);
    open_txn(1'b1);
    put(8'h0C);
    put(8'h99);
    close_txn;
    chk({16'd0, pin_out}, 32'h3322, "R9 no write in read txn");
    rd_txn(2, "R9 pointer not reloaded");

    // R3: pointer byte itself writes nothing
    wr_txn(8'h04, 8'h00, 8'h00, 8'h00, 0);
    chk({16'd0, pin_out}, 32'h3322, "R3 pointer only");
    rd_txn(1, "R3 pointer loaded");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule